// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block picks which interrupt a small 8-bit CPU core services next. Each maskable source has three attributes:

- an enable bit;
- a 2-bit software priority;
- a fixed hardware rank, where a lower source index ranks higher.

The controller holds the core's current 2-bit priority level. It selects a request in two stages. The first stage finds the highest software priority among eligible requests. The second stage breaks ties by hardware rank. A maskable request is eligible only if it is enabled and its priority is strictly above the current level. A request that is not eligible stays pending until its turn comes.

When a request wins, the block pulses `take` for one cycle and drives the vector index. It loads the winner's priority as the new current level.

- A software trap is taken at any level and forces the level to 3.
- A top-level input ranks as software priority 3 with the highest maskable rank, so it is taken whenever the current level is below 3.
- Reset leaves the level at 3, which blocks all maskable requests until the core lowers it.
- On return from a handler, the core writes the saved level through `rti_valid`/`rti_level`. Arbitration runs again in the next cycle.

External lines each OR a group of individually enabled pins. The result passes through a two-flop synchronizer and then a per-line sense selector.

- In an edge mode, a detected edge sets a pending latch.
- The latch clears when its request is taken or when software clears it.
- Peripheral requests are level flags owned by the peripherals.

A wake output lets the core leave halt mode.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is applied and right after release, `cur_level` is 3, `take` is 0 and `wake` is 0.
- R2: When several eligible requests have different software priorities, the one with the highest priority is taken, and `cur_level` becomes that priority.
- R3: When eligible requests share the top software priority, the one with the lowest source index is taken. The vector for source i is i+2. External lines are sources 0..N_EXT-1 and peripheral requests follow them.
- R4: A maskable request is taken only if its `src_en` bit is 1 and its priority (bits 2i+1:2i of `src_prio`) is strictly greater than `cur_level`. Otherwise it stays pending and is taken once `cur_level` drops below it.
- R5: A pulse on `trap_req` is latched and taken at any current level with vector 0, setting `cur_level` to 3.
- R6: The top-level input (`tli_req` with `tli_en`) acts as priority 3 and outranks every maskable source. It is taken with vector 1 when `cur_level` is below 3, and it sets `cur_level` to 3.
- R7: A taken request loads its priority into `cur_level`. A new request above that level is taken at once, which nests handlers.
- R8: The sense code of line k is bits 2k+1:2k of `ext_sense`, with 0 = falling edge, 1 = rising edge, 2 = both edges, 3 = low level. An edge latch clears when its request is taken. A low-level request stays active for as long as the line is low.
- R9: External line k is the OR of pins GRP*k..GRP*k+GRP-1, each gated by its bit in `ext_pin_en`. A disabled pin cannot raise the line.
- R10: A `sw_clr_valid` pulse naming line k discards that line's pending edge latch, so the request is never taken.
- R11: With `rti_valid` high, `cur_level` takes `rti_level` at the next edge, no `take` follows that edge, and arbitration resumes one cycle later.
- R12: `wake` is high while a trap is pending, while the top-level input is enabled and active, while any enabled external line requests, or while an enabled peripheral request whose `WAKE_MASK` bit is set is active. Peripheral 3 is excluded by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 8 | External pins, grouped GRP per line |
| ext_pin_en | input | 8 | Per-pin enable into the line OR |
| ext_sense | input | 8 | 2-bit sense code per external line |
| per_req | input | 4 | Peripheral level request flags |
| src_en | input | 8 | Enable per maskable source |
| src_prio | input | 16 | 2-bit software priority per maskable source |
| sw_clr_valid | input | 1 | Software clear strobe for an external latch |
| sw_clr_line | input | 2 | External line to clear |
| trap_req | input | 1 | Software trap request pulse |
| tli_req | input | 1 | Top-level interrupt input |
| tli_en | input | 1 | Enable for the top-level input |
| rti_valid | input | 1 | Return strobe restoring the level |
| rti_level | input | 2 | Saved level written back on return |
| take | output | 1 | One-cycle strobe: an interrupt is taken |
| take_vec | output | 4 | Vector index of the taken interrupt |
| cur_level | output | 2 | Current CPU priority level |
| wake | output | 1 | Request to leave halt mode |

## Verification
The bench queues each expected take and compares the vector and new level against the design as takes appear. Any take it did not predict is a mismatch, so the bench also catches requests taken when they should have been held.

It targets ties in software priority, which a design with a reversed rank would resolve to the wrong vector. It checks that a request at exactly the current level is held, which a non-strict comparison would take early. It checks that nothing is retaken after an edge has been serviced, which a latch that never clears would repeat. It checks that a software clear leaves no late take, and that a disabled pin in a group stays silent. It exercises all four sense codes, including low level, where a design that latches instead of following the pin would fail to retake after a return.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    typedef enum logic [1:0] {
        SENSE_FALL = 2'd0,
        SENSE_RISE = 2'd1,
        SENSE_BOTH = 2'd2,
        SENSE_LOW  = 2'd3
    } sense_e;

    localparam logic [1:0] LVL_TOP  = 2'd3;
    localparam int         VEC_TRAP = 0;
    localparam int         VEC_TLI  = 1;
    localparam int         VEC_BASE = 2;

endpackage

// File: rtl/prio_irq_edge.sv
module prio_irq_edge
    import prio_irq_pkg::*;
#(
    parameter int GRP = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [GRP-1:0] pins,
    input  logic [GRP-1:0] pin_en,
    input  logic [1:0]     sense,
    input  logic           take_clr,
    input  logic           sw_clr,
    output logic           req
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
        logic pend;
    } edge_st_t;

    edge_st_t st_d, st_q;
    sense_e   mode;
    logic     rise, fall, hit;

    always_comb begin
        mode    = sense_e'(sense);
        st_d    = st_q;
        st_d.s1 = |(pins & pin_en);
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
        rise    = st_q.s2 & ~st_q.s3;
        fall    = ~st_q.s2 & st_q.s3;
        unique case (mode)
            SENSE_FALL: hit = fall;
            SENSE_RISE: hit = rise;
            SENSE_BOTH: hit = rise | fall;
            default:    hit = 1'b0;
        endcase
        if (mode == SENSE_LOW) begin
            st_d.pend = 1'b0;
        end else begin
            // a fresh edge wins over a clear in the same cycle
            st_d.pend = hit | (st_q.pend & ~take_clr & ~sw_clr);
        end
        req = (mode == SENSE_LOW) ? ~st_q.s2 : st_q.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
    import prio_irq_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int VEC_W = 4
) (
    input  logic [N_SRC-1:0]      req,
    input  logic [N_SRC-1:0]      en,
    input  logic [N_SRC-1:0][1:0] prio,
    input  logic [1:0]            cur,
    input  logic                  trap,
    input  logic                  tli,
    output logic                  win,
    output logic [VEC_W-1:0]      win_vec,
    output logic [1:0]            win_lvl,
    output logic [N_SRC-1:0]      win_sel
);

    logic [N_SRC-1:0] elig, cand;
    logic [3:0]       lvl_hit;
    logic [1:0]       top;
    logic             found;
    int               idx;

    always_comb begin
        // stage 1: highest software level among eligible requests
        lvl_hit = '0;
        for (int i = 0; i < N_SRC; i++) begin
            elig[i] = req[i] & en[i] & (prio[i] > cur);
            if (elig[i]) lvl_hit[prio[i]] = 1'b1;
        end
        top = lvl_hit[3] ? 2'd3 : (lvl_hit[2] ? 2'd2 : 2'd1);

        // stage 2: fixed rank, lowest index first
        found = 1'b0;
        idx   = 0;
        for (int i = 0; i < N_SRC; i++) begin
            cand[i] = elig[i] & (prio[i] == top);
            if (cand[i] && !found) begin
                found = 1'b1;
                idx   = i;
            end
        end

        win     = 1'b0;
        win_vec = '0;
        win_lvl = LVL_TOP;
        win_sel = '0;
        if (trap) begin
            win     = 1'b1;
            win_vec = VEC_W'(VEC_TRAP);
        end else if (tli && cur != LVL_TOP) begin
            win     = 1'b1;
            win_vec = VEC_W'(VEC_TLI);
        end else if (found) begin
            win          = 1'b1;
            win_vec      = VEC_W'(idx + VEC_BASE);
            win_lvl      = top;
            win_sel[idx] = 1'b1;
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int               N_EXT     = 4,
    parameter int               GRP       = 2,
    parameter int               N_PER     = 4,
    parameter logic [N_PER-1:0] WAKE_MASK = 4'b0111,
    localparam int              N_SRC     = N_EXT + N_PER,
    localparam int              VEC_W     = $clog2(N_SRC + VEC_BASE),
    localparam int              LINE_W    = (N_EXT > 1) ? $clog2(N_EXT) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_EXT*GRP-1:0] ext_pin,
    input  logic [N_EXT*GRP-1:0] ext_pin_en,
    input  logic [2*N_EXT-1:0]   ext_sense,
    input  logic [N_PER-1:0]     per_req,
    input  logic [N_SRC-1:0]     src_en,
    input  logic [2*N_SRC-1:0]   src_prio,
    input  logic                 sw_clr_valid,
    input  logic [LINE_W-1:0]    sw_clr_line,
    input  logic                 trap_req,
    input  logic                 tli_req,
    input  logic                 tli_en,
    input  logic                 rti_valid,
    input  logic [1:0]           rti_level,
    output logic                 take,
    output logic [VEC_W-1:0]     take_vec,
    output logic [1:0]           cur_level,
    output logic                 wake
);

    typedef struct packed {
        logic [1:0]       lvl;
        logic             take;
        logic [VEC_W-1:0] vec;
        logic             trap_pend;
    } ctrl_st_t;

    ctrl_st_t               st_d, st_q;
    logic [N_EXT-1:0]       ext_req;
    logic [N_SRC-1:0]       src_req;
    logic [N_SRC-1:0][1:0]  prio_arr;
    logic                   win;
    logic [VEC_W-1:0]       win_vec;
    logic [1:0]             win_lvl;
    logic [N_SRC-1:0]       win_sel;
    logic [N_SRC-1:0]       take_clr;

    for (genvar k = 0; k < N_EXT; k++) begin : g_line
        prio_irq_edge #(.GRP(GRP)) u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .pins     (ext_pin[k*GRP +: GRP]),
            .pin_en   (ext_pin_en[k*GRP +: GRP]),
            .sense    (ext_sense[2*k +: 2]),
            .take_clr (take_clr[k]),
            .sw_clr   (sw_clr_valid && (sw_clr_line == LINE_W'(k))),
            .req      (ext_req[k])
        );
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_prio
        assign prio_arr[i] = src_prio[2*i +: 2];
    end

    assign src_req = {per_req, ext_req};

    prio_irq_arb #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_arb (
        .req     (src_req),
        .en      (src_en),
        .prio    (prio_arr),
        .cur     (st_q.lvl),
        .trap    (st_q.trap_pend),
        .tli     (tli_req & tli_en),
        .win     (win),
        .win_vec (win_vec),
        .win_lvl (win_lvl),
        .win_sel (win_sel)
    );

    always_comb begin
        st_d           = st_q;
        st_d.take      = 1'b0;
        st_d.trap_pend = st_q.trap_pend | trap_req;
        take_clr       = '0;
        if (rti_valid) begin
            st_d.lvl = rti_level;
        end else if (win) begin
            st_d.take = 1'b1;
            st_d.vec  = win_vec;
            st_d.lvl  = win_lvl;
            take_clr  = win_sel;
            if (win_vec == VEC_W'(VEC_TRAP)) st_d.trap_pend = trap_req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.lvl <= LVL_TOP;
        end else begin
            st_q <= st_d;
        end
    end

    assign take      = st_q.take;
    assign take_vec  = st_q.vec;
    assign cur_level = st_q.lvl;
    assign wake      = st_q.trap_pend | (tli_req & tli_en)
                     | (|(ext_req & src_en[N_EXT-1:0]))
                     | (|(per_req & src_en[N_SRC-1:N_EXT] & WAKE_MASK));

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
    parameter int VEC_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             take,
    input logic [VEC_W-1:0] take_vec,
    input logic [1:0]       cur_level,
    input logic             rti_valid,
    input logic [1:0]       rti_level
);

    // R11: a return loads its level and suppresses the next take
    a_r11_return_loads: assert property (@(posedge clk) disable iff (!rst_n)
        rti_valid |=> (cur_level == $past(rti_level)) && !take);

    // R5: trap entry leaves the level at 3
    a_r5_trap_level: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_vec == VEC_W'(0)) |-> cur_level == 2'd3);

    // R6: top-level entry leaves the level at 3
    a_r6_tli_level: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_vec == VEC_W'(1)) |-> cur_level == 2'd3);

    // R7: a maskable take always raises the level
    a_r7_level_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_vec >= VEC_W'(2)) |-> cur_level > $past(cur_level));

    // R4: at level 3 only the trap can be taken
    a_r4_top_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (take && $past(cur_level) == 2'd3) |-> take_vec == VEC_W'(0));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .take_vec  (take_vec),
    .cur_level (cur_level),
    .rti_valid (rti_valid),
    .rti_level (rti_level)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ext_pin = '0, ext_pin_en = '0;
    logic [7:0]  ext_sense = 8'h55;
    logic [3:0]  per_req = '0;
    logic [7:0]  src_en = '0;
    logic [15:0] src_prio = '0;
    logic        sw_clr_valid = 1'b0;
    logic [1:0]  sw_clr_line = '0;
    logic        trap_req = 1'b0, tli_req = 1'b0, tli_en = 1'b0;
    logic        rti_valid = 1'b0;
    logic [1:0]  rti_level = '0;
    logic        take, wake;
    logic [3:0]  take_vec;
    logic [1:0]  cur_level;

    int n_cmp = 0, n_bad = 0;
    int    q_vec[$];
    int    q_lvl[$];
    string q_tag[$];

    always #4 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_pin_en(ext_pin_en),
        .ext_sense(ext_sense), .per_req(per_req), .src_en(src_en),
        .src_prio(src_prio), .sw_clr_valid(sw_clr_valid),
        .sw_clr_line(sw_clr_line), .trap_req(trap_req), .tli_req(tli_req),
        .tli_en(tli_en), .rti_valid(rti_valid), .rti_level(rti_level),
        .take(take), .take_vec(take_vec), .cur_level(cur_level), .wake(wake)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_take(input int vec, input int lvl, input string tag);
        q_vec.push_back(vec);
        q_lvl.push_back(lvl);
        q_tag.push_back(tag);
    endtask

    // monitor: every take is matched against the queue head
    always @(negedge clk) begin
        if (rst_n && take) begin
            if (q_vec.size() == 0) begin
                chk(1'b0, "R4 unexpected take vec", int'(take_vec), -1);
            end else begin
                int ev, el;
                string tg;
                ev = q_vec.pop_front();
                el = q_lvl.pop_front();
                tg = q_tag.pop_front();
                chk(int'(take_vec) == ev, {tg, " vec"}, int'(take_vec), ev);
                chk(int'(cur_level) == el, {tg, " level"}, int'(cur_level), el);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(input string tag);
        cyc(10);
        chk(q_vec.size() == 0, {tag, " missing take"}, q_vec.size(), 0);
    endtask

    task automatic rti(input logic [1:0] lvl);
        @(negedge clk);
        rti_valid = 1'b1;
        rti_level = lvl;
        @(negedge clk);
        rti_valid = 1'b0;
    endtask

    task automatic set_src(input int i, input bit en, input logic [1:0] p);
        src_en[i]        = en;
        src_prio[2*i+:2] = p;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        cyc(3);
        chk(cur_level == 2'd3, "R1 level in reset", cur_level, 3);
        rst_n = 1'b1;
        cyc(2);
        chk(cur_level == 2'd3, "R1 level", cur_level, 3);
        chk(take == 1'b0, "R1 take", take, 0);
        chk(wake == 1'b0, "R1 wake", wake, 0);

        // R4: held at level 3, taken after return to 0
        set_src(5, 1, 2'd2); per_req[1] = 1'b1;
        cyc(6);
        chk(wake == 1'b1, "R12 wake per1", wake, 1);
        drain("R4 held");
        expect_take(7, 2, "R4");
        rti(2'd0);
        cyc(4);
        chk(cur_level == 2'd2, "R7 level after take", cur_level, 2);
        per_req[1] = 1'b0; set_src(5, 0, 2'd0);
        rti(2'd3); drain("R4");

        // R4: request at exactly the current level stays pending
        set_src(4, 1, 2'd2); per_req[0] = 1'b1;
        rti(2'd2);
        drain("R4 equal level held");
        expect_take(6, 2, "R4 after drop");
        rti(2'd1);
        drain("R4 after drop");
        per_req[0] = 1'b0; set_src(4, 0, 2'd0);
        rti(2'd3);

        // R2 and R7 nesting
        set_src(4, 1, 2'd1); set_src(7, 1, 2'd3);
        per_req[0] = 1'b1; per_req[3] = 1'b1;
        expect_take(9, 3, "R2 highest");
        rti(2'd0); cyc(4);
        per_req[3] = 1'b0; set_src(7, 0, 2'd0);
        expect_take(6, 1, "R2 next");
        rti(2'd0); cyc(4);
        chk(cur_level == 2'd1, "R7 level", cur_level, 1);
        set_src(6, 1, 2'd2);
        expect_take(8, 2, "R7 nest");
        per_req[2] = 1'b1; cyc(4);
        chk(cur_level == 2'd2, "R7 nested level", cur_level, 2);
        per_req = '0; src_en = '0; src_prio = '0;
        rti(2'd3); drain("R7");

        // R3 tie on software priority
        set_src(4, 1, 2'd2); set_src(6, 1, 2'd2);
        per_req[0] = 1'b1; per_req[2] = 1'b1;
        expect_take(6, 2, "R3 lower index");
        rti(2'd0); cyc(4);
        per_req[0] = 1'b0;
        expect_take(8, 2, "R3 next");
        rti(2'd0); cyc(4);
        per_req = '0; src_en = '0; src_prio = '0;
        rti(2'd3); drain("R3");

        // R5 trap at level 3 and at level 1
        expect_take(0, 3, "R5 at top");
        @(negedge clk); trap_req = 1'b1; @(negedge clk); trap_req = 1'b0;
        drain("R5");
        rti(2'd1);
        expect_take(0, 3, "R5 at low");
        @(negedge clk); trap_req = 1'b1; @(negedge clk); trap_req = 1'b0;
        drain("R5 low");

        // R6 top-level input
        tli_en = 1'b1; tli_req = 1'b1; set_src(5, 1, 2'd3); per_req[1] = 1'b1;
        drain("R6 held at 3");
        expect_take(1, 3, "R6 outranks");
        rti(2'd1); cyc(4);
        tli_req = 1'b0;
        expect_take(7, 3, "R6 then per");
        rti(2'd1); cyc(4);
        tli_en = 1'b0; per_req = '0; src_en = '0; src_prio = '0;
        rti(2'd3); drain("R6");

        // R8 sense modes on line 0
        set_src(0, 1, 2'd1); ext_pin_en[0] = 1'b1;
        rti(2'd0);
        expect_take(2, 1, "R8 rise");
        ext_pin[0] = 1'b1; cyc(8);
        rti(2'd0); drain("R8 latch cleared");
        ext_sense[1:0] = 2'd0;
        expect_take(2, 1, "R8 fall");
        ext_pin[0] = 1'b0; cyc(8);
        rti(2'd0);
        ext_sense[1:0] = 2'd2;
        expect_take(2, 1, "R8 both up");
        ext_pin[0] = 1'b1; cyc(8);
        rti(2'd0);
        expect_take(2, 1, "R8 both down");
        ext_pin[0] = 1'b0; cyc(8);
        rti(2'd0); drain("R8 edges");
        expect_take(2, 1, "R8 low level");
        ext_sense[1:0] = 2'd3; cyc(8);
        expect_take(2, 1, "R8 low again");
        rti(2'd0); cyc(8);
        ext_pin[0] = 1'b1; cyc(8);
        rti(2'd0); drain("R8 level released");
        ext_sense[1:0] = 2'd1; set_src(0, 0, 2'd0);
        rti(2'd3);

        // R9 grouped pins on line 1
        set_src(1, 1, 2'd2); ext_pin_en[3:2] = 2'b10;
        rti(2'd0);
        ext_pin[2] = 1'b1;
        drain("R9 disabled pin");
        expect_take(3, 2, "R9 enabled pin");
        ext_pin[3] = 1'b1; cyc(8);
        ext_pin[3:2] = 2'b00; set_src(1, 0, 2'd0);
        rti(2'd3); drain("R9");

        // R10 software clear, R12 wake, R4 enable
        set_src(2, 1, 2'd2); ext_pin_en[4] = 1'b1;
        ext_pin[4] = 1'b1; cyc(8);
        chk(wake == 1'b1, "R12 wake ext", wake, 1);
        @(negedge clk); sw_clr_valid = 1'b1; sw_clr_line = 2'd2;
        @(negedge clk); sw_clr_valid = 1'b0;
        cyc(2);
        chk(wake == 1'b0, "R10 cleared wake", wake, 0);
        set_src(7, 0, 2'd3); per_req[3] = 1'b1;
        rti(2'd0);
        drain("R10 and R4 disabled");
        chk(wake == 1'b0, "R12 disabled no wake", wake, 0);
        expect_take(9, 3, "R4 enabled");
        set_src(7, 1, 2'd3); cyc(4);
        chk(wake == 1'b0, "R12 masked per3", wake, 0);
        per_req = '0; ext_pin[4] = 1'b0; src_en = '0; src_prio = '0;
        rti(2'd3); drain("R12");

        // R11 return level
        rti(2'd2);
        chk(cur_level == 2'd2, "R11 level 2", cur_level, 2);
        rti(2'd3);
        chk(cur_level == 2'd3, "R11 level 3", cur_level, 3);
        drain("end");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule